// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block is a small target on a two-wire serial bus (I2C-compatible, 7-bit addressing) that holds the configuration image of a clock generator. It has seven 8-bit bytes. Most bits are control bits that software can write. A few bits are read-only: they show strap pins captured just after reset, the live level of a processor clock-halt input, or a fixed identification value. The whole read view is available at all times on a parallel output bus, so the output-gating logic next to the block can decode it.

Transfers are block-style. A write starts with the address byte, then two command bytes that are acknowledged and discarded, then data bytes that fill the registers from byte 0 upward. A read first returns a byte-count value, then the register bytes from byte 0 upward. The bus lines are modelled as open-drain pads: each line is an input, and the block pulls the data line low through an output enable. A fast system clock samples both lines through two-flop synchronizers, and the block detects edges from the samples. Clock stretching, 10-bit addressing and the bus's repeated-start read turnaround are not supported.

Top module: `cfg_i2c_target`

## Requirements
- R1: The block answers only to the 7-bit address 1101001. That address is followed by the direction bit: 0 means write, 1 means read. On a match, the block acknowledges by pulling SDA low during the ninth clock. On any other address it gives no acknowledge and ignores the bus until the next start or stop.
- R2: In a write, the block discards the first two bytes after the address. The next bytes go to registers 0, 1, 2 and so on. The block acknowledges every byte. The block changes SDA only while SCL is low.
- R3: A read first returns the value 0x08. After that it returns register 0, register 1 and so on, most significant bit first. Each master acknowledge moves the transfer to the next byte.
- R4: After reset the stored values are as follows: byte 0 = 0x08, byte 1 = 0x07, byte 2 = 0x7F, byte 3 = 0xC7, byte 4 = 0x3F, byte 5 = 0x00. The read-only bits are added on top of these values, and SDA is released.
- R5: The block captures the frequency-select straps in the first clock after reset and shows them in byte 0 bits 2:0. It captures the current-multiplier strap in the same clock and shows it in byte 1 bit 7. Later changes on the strap pins have no effect.
- R6: Byte 0 bit 4 always shows the current level of the clock-halt input.
- R7: Only the bits in these masks can be written: byte 0 0xA8, byte 1 0x3F, byte 2 0x7F, byte 3 0xFF, byte 4 0x3F, byte 5 0x0F.
  - Writes to all other bits are ignored.
  - The unused bits always read 0. These are byte 0 bit 6, byte 1 bit 6, byte 2 bit 7, byte 4 bits 7:6 and byte 5 bits 7:4.
  - Byte 0 bit 5 selects the shared output rate: 0 = 66 MHz, 1 = 48 MHz.
  - Byte 0 bit 7 enables spread spectrum.
- R8: Byte 6 is read-only and always reads 0x07. The identification bits 2:0 are 1, bit 3 is 0, and the revision bits 7:4 are 0.
- R9: A write past byte 6 is acknowledged and discarded. A read past byte 6 returns 0xFF.
- R10: A stop condition ends any transfer, and a byte cut short by the stop is not written. A start condition restarts the byte counter, even in the middle of a transfer.
- R11: When the master does not acknowledge a read byte, the block releases SDA. It then ignores the bus until the next start or stop.
- R12: `cfg_o` always carries the read view of the registers, with byte k on bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sel_strap_i | input | 3 | Frequency-select straps, captured after reset |
| mult_strap_i | input | 1 | Current-multiplier strap, captured after reset |
| cpu_halt_i | input | 1 | Live processor clock-halt input |
| cfg_o | output | 56 | Read view of registers 0..6 |

## Verification
The bound checker checks these properties on every cycle:
- SDA changes only while the synchronized SCL is low, except when the block releases the line on a start or stop.
- A stop always releases SDA on the next cycle.
- No register write is issued during a read transfer.
- The captured strap bits do not change once they are latched.
- The unused bits stay at zero.

Only the bench's scenarios can show the transfer-level behaviour: the address filter, the discarded command bytes, the byte-count prefix, the 0xFF tail, the restart and stop-abort cases, and the write masks. For these, the bench compares every acknowledge and every read byte with its own register model, and it compares `cfg_o` with that model on every clock.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_ACK,
        PH_SEND,
        PH_MACK,
        PH_SKIP
    } phase_e;

    // Bits software may change in each byte (R7)
    function automatic logic [7:0] wr_mask(input int idx);
        case (idx)
            0: return 8'hA8;
            1: return 8'h3F;
            2: return 8'h7F;
            3: return 8'hFF;
            4: return 8'h3F;
            5: return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    // Stored value after reset (R4)
    function automatic logic [7:0] reset_val(input int idx);
        case (idx)
            0: return 8'h08;
            1: return 8'h07;
            2: return 8'h7F;
            3: return 8'hC7;
            4: return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    // Read-only contributions: straps, live halt pin, identification (R5, R6, R8)
    function automatic logic [7:0] ro_bits(input int idx, input logic [2:0] sel,
                                           input logic mult, input logic halt);
        case (idx)
            0: return {3'b000, halt, 1'b0, sel};
            1: return {mult, 7'b0000000};
            6: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta = line_i;
        sync_d.sync = sync_q.meta;
        sync_d.prev = sync_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign lvl_o  = sync_q.sync;
    assign rise_o = sync_q.sync & ~sync_q.prev;
    assign fall_o = ~sync_q.sync & sync_q.prev;

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
    parameter int NUM_REGS = 7,
    parameter int IDXW     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [IDXW-1:0]         wr_idx_i,
    input  logic [7:0]              wr_data_i,
    input  logic [2:0]              sel_strap_i,
    input  logic                    mult_strap_i,
    input  logic                    halt_i,
    output logic [NUM_REGS*8-1:0]   rd_o,
    output logic                    strap_valid_o
);
    import cfgi2c_pkg::*;

    function automatic logic [NUM_REGS-1:0][7:0] init_image();
        logic [NUM_REGS-1:0][7:0] img;
        for (int i = 0; i < NUM_REGS; i++) img[i] = reset_val(i);
        return img;
    endfunction

    localparam logic [NUM_REGS-1:0][7:0] INIT = init_image();

    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] store;
        logic [2:0]               sel;
        logic                     mult;
        logic                     valid;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        // Straps are taken once, in the first clock after reset (R5)
        if (!regs_q.valid) begin
            regs_d.sel   = sel_strap_i;
            regs_d.mult  = mult_strap_i;
            regs_d.valid = 1'b1;
        end
        // An index past the last register matches nothing and is dropped (R9)
        if (wr_en_i) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_idx_i == IDXW'(i))
                    regs_d.store[i] = (regs_q.store[i] & ~wr_mask(i)) | (wr_data_i & wr_mask(i));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.store <= INIT;
            regs_q.sel   <= '0;
            regs_q.mult  <= 1'b0;
            regs_q.valid <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
            assign rd_o[g*8 +: 8] = (regs_q.store[g] & wr_mask(g))
                                  | ro_bits(g, regs_q.sel, regs_q.mult, halt_i);
        end
    endgenerate

    assign strap_valid_o = regs_q.valid;

endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm #(
    parameter logic [6:0] DEV_ADDR    = 7'b1101001,
    parameter int         NUM_REGS    = 7,
    parameter int         DUMMY_BYTES = 2,
    parameter logic [7:0] COUNT_BYTE  = 8'h08,
    parameter int         IDXW        = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  sda_lvl,
    input  logic                  start_evt,
    input  logic                  stop_evt,
    input  logic [NUM_REGS*8-1:0] rd_i,
    output logic                  sda_oe_o,
    output logic                  wr_en_o,
    output logic                  rd_mode_o,
    output logic [IDXW-1:0]       wr_idx_o,
    output logic [7:0]            wr_data_o
);
    import cfgi2c_pkg::*;

    localparam logic [IDXW-1:0] IDX_MAX  = '1;
    localparam logic [IDXW-1:0] IDX_SKIP = IDXW'(DUMMY_BYTES);

    typedef struct packed {
        phase_e          phase;
        logic [3:0]      bitcnt;
        logic [7:0]      shreg;
        logic [IDXW-1:0] bidx;
        logic            rw;
        logic            is_addr;
        logic            sda_oe;
        logic            mack;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [7:0]      tx_byte;
    logic [IDXW-1:0] bidx_inc;

    always_comb begin
        // Next byte to send: count prefix, registers, then 0xFF filler (R3, R9)
        tx_byte = 8'hFF;
        if (fsm_q.bidx == '0) tx_byte = COUNT_BYTE;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (fsm_q.bidx == IDXW'(i + 1)) tx_byte = rd_i[i*8 +: 8];
        end
        bidx_inc = (fsm_q.bidx == IDX_MAX) ? fsm_q.bidx : fsm_q.bidx + 1'b1;

        fsm_d     = fsm_q;
        wr_en_o   = 1'b0;
        wr_idx_o  = fsm_q.bidx - IDX_SKIP;
        wr_data_o = fsm_q.shreg;

        if (stop_evt) begin
            fsm_d.phase  = PH_IDLE;
            fsm_d.sda_oe = 1'b0;
        end else if (start_evt) begin
            fsm_d.phase   = PH_RECV;
            fsm_d.bitcnt  = '0;
            fsm_d.bidx    = '0;
            fsm_d.is_addr = 1'b1;
            fsm_d.sda_oe  = 1'b0;
        end else begin
            case (fsm_q.phase)
                PH_RECV: begin
                    if (scl_rise) begin
                        fsm_d.shreg  = {fsm_q.shreg[6:0], sda_lvl};
                        fsm_d.bitcnt = fsm_q.bitcnt + 4'd1;
                    end else if (scl_fall && fsm_q.bitcnt == 4'd8) begin
                        fsm_d.bitcnt = '0;
                        if (fsm_q.is_addr) begin
                            if (fsm_q.shreg[7:1] == DEV_ADDR) begin
                                fsm_d.rw     = fsm_q.shreg[0];
                                fsm_d.phase  = PH_ACK;
                                fsm_d.sda_oe = 1'b1;
                            end else begin
                                fsm_d.phase = PH_SKIP;
                            end
                        end else begin
                            fsm_d.phase  = PH_ACK;
                            fsm_d.sda_oe = 1'b1;
                            wr_en_o      = (fsm_q.bidx >= IDX_SKIP);
                            fsm_d.bidx   = bidx_inc;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        if (fsm_q.is_addr && fsm_q.rw) begin
                            fsm_d.shreg  = tx_byte;
                            fsm_d.sda_oe = ~tx_byte[7];
                            fsm_d.bitcnt = 4'd1;
                            fsm_d.bidx   = bidx_inc;
                            fsm_d.phase  = PH_SEND;
                        end else begin
                            fsm_d.sda_oe = 1'b0;
                            fsm_d.phase  = PH_RECV;
                        end
                        fsm_d.is_addr = 1'b0;
                    end
                end
                PH_SEND: begin
                    if (scl_fall) begin
                        if (fsm_q.bitcnt == 4'd8) begin
                            fsm_d.sda_oe = 1'b0;
                            fsm_d.phase  = PH_MACK;
                        end else begin
                            fsm_d.shreg  = {fsm_q.shreg[6:0], 1'b1};
                            fsm_d.sda_oe = ~fsm_q.shreg[6];
                            fsm_d.bitcnt = fsm_q.bitcnt + 4'd1;
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        fsm_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (fsm_q.mack) begin
                            fsm_d.shreg  = tx_byte;
                            fsm_d.sda_oe = ~tx_byte[7];
                            fsm_d.bitcnt = 4'd1;
                            fsm_d.bidx   = bidx_inc;
                            fsm_d.phase  = PH_SEND;
                        end else begin
                            fsm_d.phase = PH_SKIP;   // R11
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.phase <= PH_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe_o  = fsm_q.sda_oe;
    assign rd_mode_o = fsm_q.rw;

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b1101001,
    parameter int         NUM_REGS    = 7,
    parameter int         DUMMY_BYTES = 2,
    parameter logic [7:0] COUNT_BYTE  = 8'h08
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [2:0]            sel_strap_i,
    input  logic                  mult_strap_i,
    input  logic                  cpu_halt_i,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int IDXW = $clog2(NUM_REGS + DUMMY_BYTES + 2) + 1;

    logic [1:0] line_in, line_lvl, line_rise, line_fall;
    logic       scl_lvl, start_evt, stop_evt;
    logic       wr_en, rd_mode, strap_valid;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;

    assign line_in = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            cfg_line_sync u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (line_in[g]),
                .lvl_o  (line_lvl[g]),
                .rise_o (line_rise[g]),
                .fall_o (line_fall[g])
            );
        end
    endgenerate

    assign scl_lvl   = line_lvl[0];
    assign start_evt = scl_lvl & line_fall[1];
    assign stop_evt  = scl_lvl & line_rise[1];

    cfg_i2c_fsm #(
        .DEV_ADDR    (DEV_ADDR),
        .NUM_REGS    (NUM_REGS),
        .DUMMY_BYTES (DUMMY_BYTES),
        .COUNT_BYTE  (COUNT_BYTE),
        .IDXW        (IDXW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (line_rise[0]),
        .scl_fall  (line_fall[0]),
        .sda_lvl   (line_lvl[1]),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_i      (cfg_o),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .rd_mode_o (rd_mode),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    cfg_regs #(
        .NUM_REGS (NUM_REGS),
        .IDXW     (IDXW)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_idx_i      (wr_idx),
        .wr_data_i     (wr_data),
        .sel_strap_i   (sel_strap_i),
        .mult_strap_i  (mult_strap_i),
        .halt_i        (cpu_halt_i),
        .rd_o          (cfg_o),
        .strap_valid_o (strap_valid)
    );

endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       sda_oe,
    input logic       wr_en,
    input logic       rd_mode,
    input logic       strap_valid,
    input logic [3:0] strap_bits,
    input logic [8:0] pad_bits
);

    p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    p_sda_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_lvl);

    p_no_write_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_mode);

    p_strap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strap_valid |=> $stable(strap_bits));

    p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pad_bits == 9'd0);

endmodule

bind cfg_i2c_target cfg_i2c_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl     (scl_lvl),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .sda_oe      (sda_oe_o),
    .wr_en       (wr_en),
    .rd_mode     (rd_mode),
    .strap_valid (strap_valid),
    .strap_bits  ({cfg_o[15], cfg_o[2:0]}),
    .pad_bits    ({cfg_o[47:44], cfg_o[39:38], cfg_o[23], cfg_o[14], cfg_o[6]})
);

// File: tb/tb_cfg_i2c_target.sv
`timescale 1ns/1ps
module tb_cfg_i2c_target;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  sel = 3'b101;
    logic        mult = 1'b1;
    logic        halt = 1'b0;
    logic        sda_oe;
    logic        sda_bus;
    logic [55:0] cfg;

    int checks = 0;
    int fails = 0;
    int hold = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] m_store [7];
    logic [2:0] m_sel;
    logic       m_mult;

    assign sda_bus = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    cfg_i2c_target dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .sel_strap_i  (sel),
        .mult_strap_i (mult),
        .cpu_halt_i   (halt),
        .cfg_o        (cfg)
    );

    // Writable masks from R7
    function automatic logic [7:0] wm(input int i);
        logic [7:0] t [7] = '{8'hA8, 8'h3F, 8'h7F, 8'hFF, 8'h3F, 8'h0F, 8'h00};
        return t[i];
    endfunction

    function automatic logic [7:0] exp_byte(input int i);
        logic [7:0] v;
        v = m_store[i] & wm(i);
        if (i == 0) v = v | {3'b000, halt, 1'b0, m_sel};
        if (i == 1) v = v | {m_mult, 7'b0};
        if (i == 6) v = 8'h07;
        return v;
    endfunction

    function automatic logic [55:0] exp_vec();
        logic [55:0] v;
        for (int i = 0; i < 7; i++) v[i*8 +: 8] = exp_byte(i);
        return v;
    endfunction

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R12/R7: cycle-by-cycle comparison of the parallel view against the model
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            if (hold > 0) hold--;
            else chk(64'(cfg), 64'(exp_vec()), "R12 continuous view");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            summary();
        end
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; qwait();
        m_scl = 1'b1; qwait();
        s = sda_bus; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic put_byte(input logic [7:0] b, input int tgt, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) hold = 6 * Q;
            clk_bit(b[i], s);
        end
        if (tgt >= 0 && tgt < 7) m_store[tgt] = (m_store[tgt] & ~wm(tgt)) | (b & wm(tgt));
        clk_bit(1'b1, s);
        ack = ~s;
        m_sda = 1'b1;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
        m_sda = 1'b1;
    endtask

    task automatic read_all(input string tag);
        logic ack;
        logic [7:0] b;
        bus_start();
        put_byte(8'hD3, -1, ack);
        chk(64'(ack), 64'd1, {"R1 read address ack ", tag});
        get_byte(1'b1, b);
        chk(64'(b), 64'h08, {"R3 count byte ", tag});
        for (int i = 0; i < 7; i++) begin
            get_byte(1'b1, b);
            chk(64'(b), 64'(exp_byte(i)), (i == 6) ? {"R8 id byte ", tag} : {"R3 register byte ", tag});
        end
        get_byte(1'b0, b);
        chk(64'(b), 64'hFF, {"R9 read past end ", tag});
        repeat (4) @(negedge clk);
        chk(64'(sda_oe), 64'd0, {"R11 release after nack ", tag});
        bus_stop();
    endtask

    task automatic write_all(input logic [7:0] v, input string tag);
        logic ack;
        bus_start();
        put_byte(8'hD2, -1, ack);
        chk(64'(ack), 64'd1, {"R1 write address ack ", tag});
        put_byte(8'hA5, -1, ack);
        chk(64'(ack), 64'd1, {"R2 dummy ack ", tag});
        put_byte(8'h3C, -1, ack);
        chk(64'(ack), 64'd1, {"R2 dummy ack ", tag});
        for (int i = 0; i < 7; i++) begin
            put_byte(v, i, ack);
            chk(64'(ack), 64'd1, {"R2 data ack ", tag});
        end
        put_byte(8'h12, 7, ack);
        chk(64'(ack), 64'd1, {"R9 write past end ack ", tag});
        bus_stop();
    endtask

    initial begin
        logic ack, s;
        m_store = '{8'h08, 8'h07, 8'h7F, 8'hC7, 8'h3F, 8'h00, 8'h00};
        m_sel  = sel;
        m_mult = mult;
        repeat (5) @(negedge clk);
        hold  = 6;
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R4 reset image with straps 101, multiplier 1, halt 0
        chk(64'(cfg), 64'h07_00_3F_C7_7F_87_0D, "R4 reset image");
        chk(64'(sda_oe), 64'd0, "R4 sda released");

        read_all("after reset");

        write_all(8'hFF, "ones");
        chk(64'(cfg[7:0]), 64'hAD, "R7 byte0 after ones");
        chk(64'(cfg[47:40]), 64'h0F, "R7 byte5 after ones");
        chk(64'(cfg[55:48]), 64'h07, "R8 id after ones");
        read_all("after ones");

        write_all(8'h00, "zeros");
        chk(64'(cfg[15:8]), 64'h80, "R5 byte1 strap survives zeros");
        chk(64'(cfg[7:0]), 64'h05, "R7 byte0 after zeros");
        read_all("after zeros");

        // R5 strap pins changed later: no effect
        sel  = 3'b010;
        mult = 1'b0;
        repeat (6) @(negedge clk);
        chk(64'(cfg[2:0]), 64'd5, "R5 select straps held");
        chk(64'(cfg[15]), 64'd1, "R5 multiplier strap held");

        // R6 live halt bit
        halt = 1'b1;
        @(negedge clk);
        chk(64'(cfg[4]), 64'd1, "R6 halt high");
        read_all("halt high");
        halt = 1'b0;
        @(negedge clk);
        chk(64'(cfg[4]), 64'd0, "R6 halt low");

        // R1 foreign address ignored
        bus_start();
        put_byte(8'hA0, -1, ack);
        chk(64'(ack), 64'd0, "R1 foreign address no ack");
        put_byte(8'hFF, -1, ack);
        chk(64'(ack), 64'd0, "R1 foreign data no ack");
        bus_stop();
        chk(64'(cfg[31:24]), 64'h00, "R1 foreign write ignored");

        // R10 start mid-transfer restarts the byte counter
        bus_start();
        put_byte(8'hD2, -1, ack);
        put_byte(8'h11, -1, ack);
        bus_start();
        put_byte(8'hD2, -1, ack);
        put_byte(8'h22, -1, ack);
        put_byte(8'h33, -1, ack);
        put_byte(8'h20, 0, ack);
        bus_stop();
        chk(64'(cfg[5]), 64'd1, "R10 restart lands on byte0");
        chk(64'(cfg[23:16]), 64'h00, "R10 byte2 untouched by restart");

        // R10 stop cuts a byte short: nothing written
        bus_start();
        put_byte(8'hD2, -1, ack);
        put_byte(8'h00, -1, ack);
        put_byte(8'h00, -1, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        bus_stop();
        repeat (8) @(negedge clk);
        chk(64'(cfg[7:0]), 64'(exp_byte(0)), "R10 partial byte dropped");

        // Fresh write after abort
        bus_start();
        put_byte(8'hD2, -1, ack);
        put_byte(8'h00, -1, ack);
        put_byte(8'h00, -1, ack);
        put_byte(8'h80, 0, ack);
        chk(64'(ack), 64'd1, "R10 write after abort ack");
        bus_stop();
        chk(64'(cfg[7:0]), 64'h85, "R7 spread bit set");

        repeat (10) @(negedge clk);
        summary();
    end

endmodule